// File: doc/BRIEF.md
# Wake-Aware Interrupt Selector

This block decides which pending interrupt a processor core should take next. Each cycle it looks at a vector of pending sources, a set of partition control bits and the core's machine-state bits. It then registers one winner, or no winner. The winner comes out two ways: as an encoded index and as a one-hot vector, with a valid flag beside them.

There are two orderings. While the core is halted in power-save, each candidate source must have its own wake-enable bit set, and a pending reset is the fallback. While the core is running, each source is qualified against external enable, hypervisor mode, problem state and the partition bits. A platform that lacks a feature ties the matching control bit to zero, which disables that feature.

The output is a status stream with no back-pressure. Its contents are replaced at every rising edge, and the consumer samples them whenever it needs to. There is no ready input, and nothing is held or queued.

Top module: `irq_next_sel`

## Requirements
- R1: When `halted` is high, the block takes the first qualifying source in this order: external if `wake_en[2]`, decrementer if `wake_en[3]`, machine check if `wake_en[4]`, maintenance if `wake_en[4]`, doorbell if `wake_en[0]`, hypervisor doorbell if `wake_en[1]`.
- R2: When halted and none of the sources in R1 qualifies, a pending reset is taken whatever `wake_en` holds. If reset is not pending either, the result is none.
- R3: When running, a pending machine check wins over every other source, whatever the state bits are.
- R4: When running, a pending hypervisor decrementer is taken next, but only if `hdec_en` is high and either `ext_en` is high or `hv_mode` is low. Otherwise the selection falls through to the later rules.
- R5: When running, a pending external interrupt is taken after R3 and R4 in either of two cases. The first case is `ext_en` high, unless `hv_ext_block`, `hv_mode` and not `prob_state` all hold. The second case is `ext_route` low with `hv_mode` low, whatever `ext_en` is.
- R6: When running with `ext_en` high, the remaining sources are checked in this order: decrementer, doorbell, hypervisor doorbell, performance monitor, event branch. With `ext_en` low, none of them is taken.
- R7: An event branch is taken only when both `prob_state` and `ebb_gen` are high.
- R8: Any source that has no rule in the current mode cannot be selected: reset and maintenance while running; hypervisor decrementer, performance monitor and event branch while halted; and pending bits 10 and up in both modes.
- R9: The pending bit positions are: reset 0, machine check 1, external 2, hypervisor decrementer 3, decrementer 4, doorbell 5, hypervisor doorbell 6, maintenance 7, performance monitor 8, event branch 9. `sel_idx` carries the chosen bit position, or 15 for none. `sel_vec` has exactly that one bit set, or no bits for none. `sel_valid` is high exactly when a source is chosen.
- R10: The outputs reflect the inputs present at the previous rising edge. A synchronous `rst` drives the outputs to none with `sel_valid` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halted | input | 1 | Core is in power-save |
| pend | input | PEND_W | Pending source bits |
| wake_en | input | 5 | Per-source wake enables |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| ext_route | input | 1 | External routing bit |
| hv_ext_block | input | 1 | Blocks external delivery to the hypervisor |
| ext_en | input | 1 | Machine-state external enable |
| hv_mode | input | 1 | Machine-state hypervisor mode |
| prob_state | input | 1 | Machine-state problem state |
| ebb_gen | input | 1 | Event branch global enable |
| sel_valid | output | 1 | A source is selected |
| sel_idx | output | 4 | Selected bit position, 15 for none |
| sel_vec | output | PEND_W | One-hot form of the selection |

## Verification
The bench targets the places where a wrong design would pick the wrong winner:
- Machine check and maintenance share `wake_en[4]`. A design that swapped their order would wake on maintenance while a machine check is pending.
- When the hypervisor decrementer or external interrupt is pending but not qualified, the selection must fall through to the later rules. A design that stopped there would report none, or would lose the decrementer behind it.
- The second external case, with `ext_route` low outside hypervisor mode, must be taken with `ext_en` low. A design that forgot it would miss that interrupt.
- The event branch must not be taken outside problem state.
- While running, reset and maintenance must never appear.

Random vectors in both modes are compared against a bench model on every cycle, and a reset is asserted in the middle of the run.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int IDX_W = 4;
  localparam int NUM_RULED = 10;
  localparam int WAKE_W = 5;
  // Pending bit positions; the index output carries the same values.
  localparam logic [IDX_W-1:0] IDX_RST    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_MCK    = 4'd1;
  localparam logic [IDX_W-1:0] IDX_EXT    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_HDEC   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_DEC    = 4'd4;
  localparam logic [IDX_W-1:0] IDX_DBELL  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_HDBELL = 4'd6;
  localparam logic [IDX_W-1:0] IDX_HMI    = 4'd7;
  localparam logic [IDX_W-1:0] IDX_PERF   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_EBB    = 4'd9;
  localparam logic [IDX_W-1:0] IDX_NONE   = 4'd15;

  typedef struct packed {
    logic ext_en;
    logic hv;
    logic pr;
  } mstate_t;

  typedef struct packed {
    logic                 hit;
    logic [IDX_W-1:0]     idx;
  } pick_t;
endpackage

// File: rtl/irq_wake_pick.sv
module irq_wake_pick
  import irq_sel_pkg::*;
#(
  parameter int PEND_W = 12
) (
  input  logic [PEND_W-1:0] pend,
  input  logic [WAKE_W-1:0] wake_en,
  output pick_t             pick
);
  localparam int NCAND = 7;

  logic [NCAND-1:0] cand;
  logic [IDX_W-1:0] cid [NCAND];

  // Candidates listed in wake priority order, slot 0 first.
  always_comb begin
    cid[0] = IDX_EXT;    cand[0] = pend[IDX_EXT]    & wake_en[2];
    cid[1] = IDX_DEC;    cand[1] = pend[IDX_DEC]    & wake_en[3];
    cid[2] = IDX_MCK;    cand[2] = pend[IDX_MCK]    & wake_en[4];
    cid[3] = IDX_HMI;    cand[3] = pend[IDX_HMI]    & wake_en[4];
    cid[4] = IDX_DBELL;  cand[4] = pend[IDX_DBELL]  & wake_en[0];
    cid[5] = IDX_HDBELL; cand[5] = pend[IDX_HDBELL] & wake_en[1];
    cid[6] = IDX_RST;    cand[6] = pend[IDX_RST];
  end

  // Scan from lowest priority upward so the earliest slot wins.
  always_comb begin
    pick.hit = 1'b0;
    pick.idx = IDX_NONE;
    for (int i = NCAND - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick.hit = 1'b1;
        pick.idx = cid[i];
      end
    end
  end
endmodule

// File: rtl/irq_run_pick.sv
module irq_run_pick
  import irq_sel_pkg::*;
#(
  parameter int PEND_W = 12
) (
  input  logic [PEND_W-1:0] pend,
  input  mstate_t           ms,
  input  logic              hdec_en,
  input  logic              ext_route,
  input  logic              hv_ext_block,
  input  logic              ebb_gen,
  output pick_t             pick
);
  logic hdec_ok, ext_ok, ebb_ok;

  assign hdec_ok = pend[IDX_HDEC] & hdec_en & (ms.ext_en | ~ms.hv);
  assign ext_ok  = pend[IDX_EXT] &
                   ((ms.ext_en & ~(hv_ext_block & ms.hv & ~ms.pr)) |
                    (~ext_route & ~ms.hv));
  assign ebb_ok  = pend[IDX_EBB] & ms.pr & ebb_gen;

  always_comb begin
    pick.hit = 1'b1;
    if (pend[IDX_MCK])                        pick.idx = IDX_MCK;
    else if (hdec_ok)                         pick.idx = IDX_HDEC;
    else if (ext_ok)                          pick.idx = IDX_EXT;
    else if (ms.ext_en && pend[IDX_DEC])      pick.idx = IDX_DEC;
    else if (ms.ext_en && pend[IDX_DBELL])    pick.idx = IDX_DBELL;
    else if (ms.ext_en && pend[IDX_HDBELL])   pick.idx = IDX_HDBELL;
    else if (ms.ext_en && pend[IDX_PERF])     pick.idx = IDX_PERF;
    else if (ms.ext_en && ebb_ok)             pick.idx = IDX_EBB;
    else begin
      pick.hit = 1'b0;
      pick.idx = IDX_NONE;
    end
  end
endmodule

// File: rtl/irq_onehot_enc.sv
module irq_onehot_enc
  import irq_sel_pkg::*;
#(
  parameter int PEND_W = 12
) (
  input  logic              valid,
  input  logic [IDX_W-1:0]  idx,
  output logic [PEND_W-1:0] vec
);
  for (genvar g = 0; g < PEND_W; g++) begin : g_bit
    if (g < NUM_RULED) begin : g_ruled
      assign vec[g] = valid && (idx == IDX_W'(g));
    end else begin : g_unruled
      assign vec[g] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_next_sel.sv
module irq_next_sel
  import irq_sel_pkg::*;
#(
  parameter int PEND_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic [PEND_W-1:0] pend,
  input  logic [4:0]        wake_en,
  input  logic              hdec_en,
  input  logic              ext_route,
  input  logic              hv_ext_block,
  input  logic              ext_en,
  input  logic              hv_mode,
  input  logic              prob_state,
  input  logic              ebb_gen,
  output logic              sel_valid,
  output logic [3:0]        sel_idx,
  output logic [PEND_W-1:0] sel_vec
);
  mstate_t ms;
  pick_t   wake_pick, run_pick, next_pick;
  logic    valid_q;
  logic [IDX_W-1:0] idx_q;

  assign ms = '{ext_en: ext_en, hv: hv_mode, pr: prob_state};

  irq_wake_pick #(.PEND_W(PEND_W)) u_wake (
    .pend    (pend),
    .wake_en (wake_en),
    .pick    (wake_pick)
  );

  irq_run_pick #(.PEND_W(PEND_W)) u_run (
    .pend         (pend),
    .ms           (ms),
    .hdec_en      (hdec_en),
    .ext_route    (ext_route),
    .hv_ext_block (hv_ext_block),
    .ebb_gen      (ebb_gen),
    .pick         (run_pick)
  );

  assign next_pick = halted ? wake_pick : run_pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= IDX_NONE;
    end else begin
      valid_q <= next_pick.hit;
      idx_q   <= next_pick.idx;
    end
  end

  irq_onehot_enc #(.PEND_W(PEND_W)) u_enc (
    .valid (valid_q),
    .idx   (idx_q),
    .vec   (sel_vec)
  );

  assign sel_valid = valid_q;
  assign sel_idx   = idx_q;
endmodule

// File: rtl/irq_next_sel_chk.sv
module irq_next_sel_chk
  import irq_sel_pkg::*;
#(
  parameter int PEND_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [PEND_W-1:0] pend,
  input logic [4:0]        wake_en,
  input logic              hdec_en,
  input logic              ext_route,
  input logic              hv_ext_block,
  input logic              ext_en,
  input logic              hv_mode,
  input logic              prob_state,
  input logic              ebb_gen,
  input logic              sel_valid,
  input logic [3:0]        sel_idx,
  input logic [PEND_W-1:0] sel_vec
);
  assert_onehot_R9: assert property (@(posedge clk) $onehot0(sel_vec));

  assert_valid_vec_R9: assert property (@(posedge clk) disable iff (rst)
    sel_valid == (sel_vec != '0));

  assert_idx_bit_R9: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_idx < 4'(NUM_RULED)) && sel_vec[sel_idx]);

  assert_none_idx_R9: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> sel_idx == IDX_NONE);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !sel_valid && sel_idx == IDX_NONE);

  assert_mck_run_R3: assert property (@(posedge clk) disable iff (rst)
    (!halted && pend[IDX_MCK]) |=> sel_valid && sel_idx == IDX_MCK);

  assert_halt_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (halted && pend[IDX_RST]) |=> sel_valid);

  assert_run_no_rst_R8: assert property (@(posedge clk) disable iff (rst)
    !halted |=> !(sel_vec[IDX_RST] || sel_vec[IDX_HMI]));

  assert_ebb_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !(prob_state && ebb_gen) |=> !sel_vec[IDX_EBB]);
endmodule

bind irq_next_sel irq_next_sel_chk #(.PEND_W(PEND_W)) u_chk (.*);

// File: tb/tb_irq_next_sel.sv
module tb_irq_next_sel;
  localparam int CLK_P = 10;
  localparam int PW = 12;
  localparam logic [3:0] NONE = 4'd15;

  logic clk = 1'b0;
  logic rst;
  logic halted, hdec_en, ext_route, hv_ext_block, ext_en, hv_mode, prob_state, ebb_gen;
  logic [PW-1:0] pend;
  logic [4:0] wake_en;
  logic sel_valid;
  logic [3:0] sel_idx;
  logic [PW-1:0] sel_vec;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_next_sel #(.PEND_W(PW)) dut (.*);

  function automatic logic [3:0] model();
    if (halted) begin
      if (pend[2] && wake_en[2]) return 4'd2;
      if (pend[4] && wake_en[3]) return 4'd4;
      if (pend[1] && wake_en[4]) return 4'd1;
      if (pend[7] && wake_en[4]) return 4'd7;
      if (pend[5] && wake_en[0]) return 4'd5;
      if (pend[6] && wake_en[1]) return 4'd6;
      if (pend[0]) return 4'd0;
      return NONE;
    end
    if (pend[1]) return 4'd1;
    if (pend[3] && hdec_en && (ext_en || !hv_mode)) return 4'd3;
    if (pend[2]) begin
      if (ext_en && !(hv_ext_block && hv_mode && !prob_state)) return 4'd2;
      if (!ext_route && !hv_mode) return 4'd2;
    end
    if (!ext_en) return NONE;
    if (pend[4]) return 4'd4;
    if (pend[5]) return 4'd5;
    if (pend[6]) return 4'd6;
    if (pend[8]) return 4'd8;
    if (pend[9] && prob_state && ebb_gen) return 4'd9;
    return NONE;
  endfunction

  task automatic compare(input logic [3:0] exp_idx, input string req);
    logic [PW-1:0] exp_vec;
    logic exp_v;
    exp_v = (exp_idx != NONE);
    exp_vec = exp_v ? (PW'(1) << exp_idx) : '0;
    n_chk++;
    if (sel_idx !== exp_idx || sel_valid !== exp_v || sel_vec !== exp_vec) begin
      n_bad++;
      $display("FAIL %s: idx=%0d valid=%0b vec=%h expected idx=%0d valid=%0b vec=%h",
               req, sel_idx, sel_valid, sel_vec, exp_idx, exp_v, exp_vec);
    end
  endtask

  // Called at a negedge: apply, pass one rising edge, sample at next negedge.
  task automatic step(input string req);
    logic [3:0] e;
    e = model();
    @(negedge clk);
    compare(e, req);
  endtask

  task automatic setup(input logic h, input logic [PW-1:0] p, input logic [4:0] w,
                       input logic hd, input logic rt, input logic hb,
                       input logic ee, input logic hv, input logic pr, input logic eg);
    halted = h; pend = p; wake_en = w; hdec_en = hd; ext_route = rt;
    hv_ext_block = hb; ext_en = ee; hv_mode = hv; prob_state = pr; ebb_gen = eg;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    setup(0, '0, '0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    compare(NONE, "R10 reset state");
    rst = 1'b0;

    // Halted ordering
    setup(1, 12'h3FF, 5'h00, 1, 1, 0, 1, 0, 1, 1); step("R2 reset fallback");
    setup(1, 12'h000, 5'h1F, 0, 0, 0, 1, 0, 0, 0); step("R2 none");
    setup(1, 12'h0FF, 5'h1F, 0, 0, 0, 0, 0, 0, 0); step("R1 ext first");
    setup(1, 12'h082, 5'h10, 0, 0, 0, 0, 0, 0, 0); step("R1 mck before hmi");
    setup(1, 12'h080, 5'h10, 0, 0, 0, 0, 0, 0, 0); step("R1 hmi via bit4");
    setup(1, 12'h060, 5'h02, 0, 0, 0, 0, 0, 0, 0); step("R1 hdbell bit1");
    setup(1, 12'hF08, 5'h1F, 1, 0, 0, 1, 0, 1, 1); step("R8 halted ignores hdec perf ebb");
    // Running ordering
    setup(0, 12'h3FE, 5'h00, 1, 0, 0, 0, 1, 0, 0); step("R3 mck unconditional");
    setup(0, 12'h018, 5'h00, 1, 1, 0, 0, 1, 0, 0); step("R4 hdec blocked falls through");
    setup(0, 12'h018, 5'h00, 1, 1, 0, 0, 0, 0, 0); step("R4 hdec outside hv");
    setup(0, 12'h014, 5'h00, 0, 1, 1, 1, 1, 0, 0); step("R5 ext blocked to hv");
    setup(0, 12'h004, 5'h00, 0, 1, 1, 1, 1, 1, 0); step("R5 ext in hv problem state");
    setup(0, 12'h004, 5'h00, 0, 0, 0, 0, 0, 0, 0); step("R5 ext via routing");
    setup(0, 12'h370, 5'h00, 0, 1, 0, 1, 1, 0, 0); step("R6 dec first");
    setup(0, 12'h300, 5'h00, 0, 1, 0, 1, 1, 1, 1); step("R6 perf before ebb");
    setup(0, 12'h370, 5'h00, 0, 1, 0, 0, 1, 0, 0); step("R6 ext_en low");
    setup(0, 12'h200, 5'h00, 0, 1, 0, 1, 1, 0, 1); step("R7 ebb needs problem state");
    setup(0, 12'h200, 5'h00, 0, 1, 0, 1, 1, 1, 1); step("R7 ebb taken");
    setup(0, 12'hC81, 5'h1F, 0, 1, 0, 1, 1, 1, 1); step("R8 running ignores rst hmi high bits");

    // Random phase
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 4000; i++) begin
      setup($urandom_range(0, 1), PW'($urandom), 5'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      if (i == 2000) begin
        rst = 1'b1;
        @(negedge clk);
        compare(NONE, "R10 mid-run reset");
        rst = 1'b0;
      end
      step(halted ? "R1 random halted" : "R6 random running");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule